// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a byte-wide non-volatile memory. While an internal programming cycle is in progress it replaces array data with a status image on the data bus, so that a host can find out when the write has finished without an extra interrupt line. The block supports two polling methods, and both are present in every busy-time read.

The first method places the inverse of the most significant bit of the last byte written in bit 7. A host that compares bit 7 against its own copy of that byte sees a mismatch until programming completes. The second method flips bit 6 on each new read access, so two back-to-back reads that differ in bit 6 mean the device is still busy. When the busy flag drops, reads return true array contents and bit 6 stops moving.

The strobes arrive already sampled into the block's clock domain. A read lasts as long as chip-select and output-enable are both low. The data bus and its drive enable are registered, so they follow the strobes one clock later.

Top module: `wcs_reporter`

## Requirements
- R1: While reset is asserted, and on the first output cycle after it, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: `rd_drive` is 1 in the cycle after one in which `ce_n` and `oe_n` are both low, and 0 otherwise. While `rd_drive` is 0, `rd_data` is all zeros.
- R3: When a read is in progress and `prog_busy` is 0, `rd_data` equals `array_rdata` of the previous cycle.
- R4: When a read is in progress and `prog_busy` is 1, bit 7 of `rd_data` is the inverse of bit 7 of `last_wdata`.
- R5: While busy, bit 6 changes value once at the start of each new read access, that is, in the first cycle in which both strobes are low after a cycle in which they were not. It holds its value for the rest of that access.
- R6: While busy, bits 5 down to 0 of the status image are zero.
- R7: A rising edge of `prog_busy` clears the toggle state, so the first read access of every programming cycle returns bit 6 as 1.
- R8: Once `prog_busy` falls, the next read output carries true array data in all bits, including bits 7 and 6, and further reads while idle leave the toggle state unchanged.
- R9: While busy, `array_rdata` has no effect on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Sampled chip-select, active low |
| oe_n | input | 1 | Sampled output-enable, active low |
| prog_busy | input | 1 | High while an internal programming cycle runs |
| last_wdata | input | DATA_W | Byte most recently accepted for programming |
| array_rdata | input | DATA_W | Array contents at the current address |
| rd_data | output | DATA_W | Registered read data or status image |
| rd_drive | output | 1 | Registered output-drive enable |

## Verification
On every cycle, the bound checker confirms the following:
- The bus is undriven and all zeros outside a read.
- Reads while idle forward the array byte one cycle later.
- Busy reads carry the inverted bit 7 with zero reserved bits.
- Bit 6 stays put while an access is held.

The scenarios in the bench cover what needs a history across several accesses:
- Bit 6 alternates across separate reads.
- The toggle state clears when a new programming cycle starts.
- The toggle freezes at completion.
- Array data is ignored during busy reads.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Which value the read bus carries in the next cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } src_e;

    // Bit positions inside the status image, counted from the MSB.
    localparam int POLL_OFS = 1;
    localparam int TOG_OFS  = 2;

endpackage

// File: rtl/wcs_strobe_decode.sv
module wcs_strobe_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic rd_prev,
    output logic rd_act,
    output logic rd_start
);

    always_comb begin
        rd_act   = !ce_n && !oe_n;
        rd_start = rd_act && !rd_prev;
    end

endmodule

// File: rtl/wcs_toggle_next.sv
module wcs_toggle_next (
    input  logic busy,
    input  logic busy_prev,
    input  logic rd_start,
    input  logic tog_q,
    output logic tog_d
);

    logic base;

    always_comb begin
        // A fresh programming cycle starts the toggle from zero.
        base  = (busy && !busy_prev) ? 1'b0 : tog_q;
        tog_d = (busy && rd_start) ? !base : base;
    end

endmodule

// File: rtl/wcs_image_mux.sv
module wcs_image_mux
    import wcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  src_e              src,
    input  logic              poll_src_bit,
    input  logic              tog,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] image
);

    localparam int POLL_BIT = DATA_W - POLL_OFS;
    localparam int TOG_BIT  = DATA_W - TOG_OFS;

    logic [DATA_W-1:0] status;

    always_comb begin
        status           = '0;
        status[POLL_BIT] = !poll_src_bit;
        status[TOG_BIT]  = tog;
        unique case (src)
            SRC_ARRAY:  image = array_rdata;
            SRC_STATUS: image = status;
            default:    image = '0;
        endcase
    end

endmodule

// File: rtl/wcs_reporter.sv
module wcs_reporter
    import wcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] last_wdata,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    typedef struct packed {
        logic              rd_prev;
        logic              busy_prev;
        logic              tog;
        logic              drive;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic rd_act, rd_start, tog_d;
    src_e src;
    logic [DATA_W-1:0] image;

    wcs_strobe_decode u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rd_prev  (st_q.rd_prev),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    wcs_toggle_next u_tog (
        .busy      (prog_busy),
        .busy_prev (st_q.busy_prev),
        .rd_start  (rd_start),
        .tog_q     (st_q.tog),
        .tog_d     (tog_d)
    );

    always_comb begin
        if (!rd_act)        src = SRC_NONE;
        else if (prog_busy) src = SRC_STATUS;
        else                src = SRC_ARRAY;
    end

    wcs_image_mux #(.DATA_W(DATA_W)) u_mux (
        .src          (src),
        .poll_src_bit (last_wdata[DATA_W-1]),
        .tog          (tog_d),
        .array_rdata  (array_rdata),
        .image        (image)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rd_prev   = rd_act;
        st_d.busy_prev = prog_busy;
        st_d.tog       = tog_d;
        st_d.drive     = rd_act;
        st_d.data      = image;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_drive = st_q.drive;

endmodule

// File: rtl/wcs_reporter_chk.sv
module wcs_reporter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_busy,
    input logic [DATA_W-1:0] last_wdata,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive
);

    logic rd;
    logic warm_q;

    assign rd = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rd_drive && rd_data == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (!rd_drive && rd_data == '0)); // R2

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_drive); // R2

    AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !prog_busy) |=> (rd_data == $past(array_rdata))); // R3

    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && prog_busy) |=> (rd_data[DATA_W-1] == !$past(last_wdata[DATA_W-1]))); // R4

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && prog_busy) |=> (rd_data[DATA_W-3:0] == '0)); // R6

    AST_TOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && rd && prog_busy && $past(rd) && $past(prog_busy))
        |=> $stable(rd_data[DATA_W-2])); // R5

endmodule

bind wcs_reporter wcs_reporter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .prog_busy   (prog_busy),
    .last_wdata  (last_wdata),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .rd_drive    (rd_drive)
);

// File: tb/wcs_reporter_test.sv
module wcs_reporter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       prog_busy = 1'b0;
    logic [7:0] last_wdata = 8'h00;
    logic [7:0] array_rdata = 8'h00;
    logic [7:0] rd_data;
    logic       rd_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcs_reporter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .prog_busy   (prog_busy),
        .last_wdata  (last_wdata),
        .array_rdata (array_rdata),
        .rd_data     (rd_data),
        .rd_drive    (rd_drive)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic drv_exp, logic [7:0] data_exp);
        n_chk++;
        if (rd_drive !== drv_exp || rd_data !== data_exp) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%02h expected drive=%0b data=%02h",
                     req, rd_drive, rd_data, drv_exp, data_exp);
        end
    endtask

    task automatic rd_on();  ce_n = 1'b0; oe_n = 1'b0; step(); endtask
    task automatic rd_off(); oe_n = 1'b1; step(); endtask

    task automatic t_reset();
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; array_rdata = 8'hA5;
        step();
        chk("R1 in reset", 1'b0, 8'h00);
        ce_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;
        step();
        chk("R1 after reset", 1'b0, 8'h00);
    endtask

    task automatic t_idle();
        array_rdata = 8'h3C;
        ce_n = 1'b0; oe_n = 1'b1; step();
        chk("R2 oe high", 1'b0, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0; step();
        chk("R2 ce high", 1'b0, 8'h00);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_normal();
        prog_busy = 1'b0; array_rdata = 8'h5A;
        rd_on();
        chk("R3 read", 1'b1, 8'h5A);
        array_rdata = 8'hC3; step();
        chk("R3 address change", 1'b1, 8'hC3);
        rd_off();
        chk("R2 read ends", 1'b0, 8'h00);
    endtask

    task automatic t_busy_poll();
        prog_busy = 1'b1; last_wdata = 8'h37; array_rdata = 8'hFF;
        step();
        rd_on();
        chk("R7 R4 R6 first poll", 1'b1, 8'hC0);
        step();
        chk("R5 held access", 1'b1, 8'hC0);
        rd_off();
        chk("R2 busy read ends", 1'b0, 8'h00);
        rd_on();
        chk("R5 second poll", 1'b1, 8'h80);
        rd_off();
        rd_on();
        chk("R5 third poll", 1'b1, 8'hC0);
        rd_off();
        last_wdata = 8'hB5; array_rdata = 8'h00;
        rd_on();
        chk("R4 bit7 one", 1'b1, 8'h00);
        array_rdata = 8'h7E; step();
        chk("R9 array ignored", 1'b1, 8'h00);
        rd_off();
    endtask

    task automatic t_complete();
        prog_busy = 1'b0; array_rdata = 8'h6E; step();
        rd_on();
        chk("R8 true data", 1'b1, 8'h6E);
        rd_off();
        rd_on();
        chk("R8 no toggle idle", 1'b1, 8'h6E);
        rd_off();
    endtask

    task automatic t_restart();
        last_wdata = 8'h37;
        prog_busy = 1'b1; step();
        rd_on();
        chk("R7 fresh cycle", 1'b1, 8'hC0);
        rd_off();
        prog_busy = 1'b0; step();
        prog_busy = 1'b1; step();
        rd_on();
        chk("R7 cleared on restart", 1'b1, 8'hC0);
        rd_off();
        prog_busy = 1'b0; step();
    endtask

    initial begin
        step();
        t_reset();
        t_idle();
        t_normal();
        t_busy_poll();
        t_complete();
        t_restart();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule